// File: doc/BRIEF.md
# Interleaved Operand Memory Mapper

This block places big-number operands into a shared operand SRAM whose layout interleaves three operand slices, and reads a result back out of that SRAM. An operand arrives as a byte stream, most significant byte first. Its type (exponent, modulus or message data) and its byte count are given with a start pulse. Each accepted byte becomes one byte-lane write at the interleaved address for its significance. The rest of the operand's slice is then filled with zeros. While bytes stream in, the block finds the highest set bit and reports the operand's bit length.

For readback, a start pulse makes the block walk the data slice one dword per cycle, beginning at the most significant end. It stops at the first nonzero dword and reports how many bytes remain once the leading zero bytes are removed. The SRAM sits outside the block and has a one-cycle read latency.

The controller has six states. ST_IDLE waits for a start. ST_LOAD accepts stream bytes. ST_PAD writes zero fill. ST_SCAN reads the data slice downward. ST_DONE raises the completion pulse. ST_FAULT raises completion together with the error flag.

The transitions are:
- ST_IDLE to ST_LOAD on a valid load with a nonzero length.
- ST_IDLE to ST_PAD on a valid load of length zero.
- ST_IDLE to ST_FAULT on an illegal select or an oversize length.
- ST_IDLE to ST_SCAN on a read start.
- ST_LOAD to ST_PAD after the last byte, when the slice is not yet full.
- ST_LOAD to ST_DONE after the last byte, when the slice is full.
- ST_PAD to ST_DONE after the last fill byte.
- ST_SCAN to ST_DONE once a nonzero dword is seen or the bottom dword has been checked.
- ST_DONE and ST_FAULT back to ST_IDLE.

Top module: `opmem_mapper`

## Requirements
- R1: The SRAM is dword addressed in groups of 12 dwords. Dword k of an operand (counted from the least significant end) sits at address (k/4)*12 + 4*sel + (k mod 4). The select is sel=0 for exponent, 1 for modulus and 2 for data. No address reaches 1536 or beyond.
- R2: The operand byte with index b, counted from the least significant byte, is written to byte lane b mod 4 of operand dword b/4. Every write has exactly one bit set in `mem_be`, with lane j on bits [8j+7:8j], and the byte is repeated in all four lanes of `mem_wdata`.
- R3: Bytes are streamed most significant first. `in_ready` is high only while bytes are being accepted. Each cycle with `in_valid` and `in_ready` both high consumes one byte and performs one write. Idle cycles between bytes are allowed.
- R4: After the last streamed byte, the block zero-writes every byte index from the load length up to the slice capacity minus one, in ascending order. The capacity is 512 bytes for sel 0 and 1, and 2048 bytes for sel 2.
- R5: `bit_len` equals 8 times the index of the highest nonzero byte, plus the 1-based position of that byte's top set bit. Leading zero bytes do not count, and an all-zero operand gives 0.
- R6: A read start scans the data slice from its top dword downward. `res_len` becomes the index of the highest nonzero data byte plus one, or 0 if the whole slice is zero.
- R7: `done` is a single-cycle pulse. It comes in the cycle after the final write of a load, or after the scan has decided its result.
- R8: A load with sel=3, or with a length above the slice capacity, writes nothing and accepts no byte. It leaves `bit_len` at 0 and produces `done` and `err` together in the cycle after the start.
- R9: A load of length 0 performs only the zero fill. A load of exactly the capacity performs no fill writes.
- R10: While reset is held, `done`, `err`, `in_ready`, `mem_we`, `mem_re`, `bit_len` and `res_len` are all zero.
- R11: A load changes only bytes of its own slice. The other two slices keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_start | input | 1 | Load start pulse |
| ld_sel | input | 2 | Operand select: 0 exponent, 1 modulus, 2 data, 3 illegal |
| ld_len | input | 12 | Operand byte count |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte, most significant first |
| in_ready | output | 1 | Stream byte accepted this cycle when valid |
| rd_start | input | 1 | Readback start pulse |
| mem_we | output | 1 | SRAM write enable |
| mem_re | output | 1 | SRAM read enable |
| mem_addr | output | 11 | SRAM dword address |
| mem_be | output | 4 | SRAM byte-lane enable |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data, one cycle after `mem_re` |
| done | output | 1 | Completion pulse |
| err | output | 1 | Rejected load, valid with `done` |
| bit_len | output | 15 | Bit length of the last loaded operand |
| res_len | output | 12 | Stripped byte length from the last readback |

## Verification
Operands are sent with leading zero bytes, with a top bit at the very top, with all-zero content, and with idle gaps in the stream. These cases separate correct bit-length counting from counting that includes leading zeros or off-by-one bit positions. Lengths of zero, a few bytes, exactly the capacity and one above it exercise padding and rejection at both edges. Loads of all three slices into an SRAM pre-filled with a nonzero pattern show whether any slice or padding write lands on the wrong dword or lane. Readback on data with inner zero bytes, a full-length value and an empty slice tells apart the scan stopping points.

// File: rtl/opmem_pkg.sv
`timescale 1ns/1ps
package opmem_pkg;

    typedef enum logic [1:0] {
        OP_EXP  = 2'd0,
        OP_MOD  = 2'd1,
        OP_DATA = 2'd2,
        OP_BAD  = 2'd3
    } op_sel_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PAD,
        ST_SCAN,
        ST_DONE,
        ST_FAULT
    } map_state_t;

    // words per operand slice inside one group, and slices per group
    localparam int SLICE_WORDS = 4;
    localparam int SLICE_LG    = 2;
    localparam int NUM_SLICES  = 3;
    localparam int GROUP_WORDS = SLICE_WORDS * NUM_SLICES;

endpackage

// File: rtl/opmem_addr_map.sv
`timescale 1ns/1ps
module opmem_addr_map
    import opmem_pkg::*;
#(
    parameter int WIDX_W = 9,
    parameter int ADDR_W = 11
) (
    input  logic [1:0]        sel,
    input  logic [WIDX_W-1:0] widx,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] grp;
    logic [ADDR_W-1:0] slice_base;
    logic [ADDR_W-1:0] in_slice;

    always_comb begin
        grp        = ADDR_W'(widx >> SLICE_LG);
        slice_base = ADDR_W'(sel) * ADDR_W'(SLICE_WORDS);
        in_slice   = ADDR_W'(widx[SLICE_LG-1:0]);
        addr       = grp * ADDR_W'(GROUP_WORDS) + slice_base + in_slice;
    end
endmodule

// File: rtl/opmem_byte_msb.sv
`timescale 1ns/1ps
module opmem_byte_msb (
    input  logic [7:0] byte_in,
    output logic [3:0] nbits
);
    always_comb begin
        nbits = '0;
        for (int i = 0; i < 8; i++) begin
            if (byte_in[i]) nbits = 4'(i + 1);
        end
    end
endmodule

// File: rtl/opmem_word_top.sv
`timescale 1ns/1ps
module opmem_word_top #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0]       word_in,
    output logic                     any_nz,
    output logic [$clog2(LANES):0]   top_cnt
);
    logic [LANES-1:0] lane_nz;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_nz[g] = |word_in[8*g +: 8];
    end

    always_comb begin
        any_nz  = |lane_nz;
        top_cnt = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_nz[i]) top_cnt = ($clog2(LANES)+1)'(i + 1);
        end
    end
endmodule

// File: rtl/opmem_mapper.sv
`timescale 1ns/1ps
module opmem_mapper
    import opmem_pkg::*;
#(
    parameter int DATA_BYTES = 2048,
    parameter int LEN_W      = $clog2(DATA_BYTES) + 1,
    parameter int ADDR_W     = $clog2((DATA_BYTES / 4) * NUM_SLICES),
    parameter int BITLEN_W   = LEN_W + 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_start,
    input  logic [1:0]          ld_sel,
    input  logic [LEN_W-1:0]    ld_len,
    input  logic                in_valid,
    input  logic [7:0]          in_data,
    output logic                in_ready,
    input  logic                rd_start,
    output logic                mem_we,
    output logic                mem_re,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [3:0]          mem_be,
    output logic [31:0]         mem_wdata,
    input  logic [31:0]         mem_rdata,
    output logic                done,
    output logic                err,
    output logic [BITLEN_W-1:0] bit_len,
    output logic [LEN_W-1:0]    res_len
);
    localparam int KEY_BYTES  = DATA_BYTES / 4;
    localparam int DATA_WORDS = DATA_BYTES / 4;
    localparam int BIDX_W     = $clog2(DATA_BYTES);
    localparam int WIDX_W     = BIDX_W - 2;

    function automatic logic [LEN_W-1:0] cap_of(input logic [1:0] s);
        return (s == OP_DATA) ? LEN_W'(DATA_BYTES) : LEN_W'(KEY_BYTES);
    endfunction

    map_state_t          state_q, state_d;
    logic [1:0]          cur_sel;
    logic [LEN_W-1:0]    rem_cnt;
    logic [LEN_W-1:0]    pad_idx;
    logic                found_q;
    logic [BITLEN_W-1:0] bit_len_q;
    logic [LEN_W-1:0]    res_len_q;
    logic [WIDX_W-1:0]   scan_k;
    logic                scan_more;
    logic                chk_vld;
    logic [WIDX_W-1:0]   chk_k;

    logic [LEN_W-1:0]    cap_cur;
    logic [BIDX_W-1:0]   wr_bidx;
    logic [1:0]          map_sel;
    logic [WIDX_W-1:0]   map_widx;
    logic [ADDR_W-1:0]   map_addr;
    logic [3:0]          msb_n;
    logic                word_any;
    logic [2:0]          word_top;
    logic                load_bad;
    logic                byte_take;

    assign cap_cur   = cap_of(cur_sel);
    assign load_bad  = (ld_sel == OP_BAD) || (ld_len > cap_of(ld_sel));
    assign byte_take = (state_q == ST_LOAD) && in_valid;

    // byte index being written: streamed byte or fill position
    always_comb begin
        if (state_q == ST_PAD) wr_bidx = pad_idx[BIDX_W-1:0];
        else                   wr_bidx = BIDX_W'(rem_cnt - 1'b1);
    end

    always_comb begin
        if (state_q == ST_SCAN) begin
            map_sel  = OP_DATA;
            map_widx = scan_k;
        end else begin
            map_sel  = cur_sel;
            map_widx = wr_bidx[BIDX_W-1:2];
        end
    end

    opmem_addr_map #(.WIDX_W(WIDX_W), .ADDR_W(ADDR_W)) u_map (
        .sel  (map_sel),
        .widx (map_widx),
        .addr (map_addr)
    );

    opmem_byte_msb u_msb (
        .byte_in (in_data),
        .nbits   (msb_n)
    );

    opmem_word_top #(.LANES(4)) u_top (
        .word_in (mem_rdata),
        .any_nz  (word_any),
        .top_cnt (word_top)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ld_start) begin
                    if (load_bad)         state_d = ST_FAULT;
                    else if (ld_len == 0) state_d = ST_PAD;
                    else                  state_d = ST_LOAD;
                end else if (rd_start) begin
                    state_d = ST_SCAN;
                end
            end
            ST_LOAD: begin
                if (in_valid && rem_cnt == LEN_W'(1)) begin
                    state_d = (pad_idx == cap_cur) ? ST_DONE : ST_PAD;
                end
            end
            ST_PAD: begin
                if (pad_idx == cap_cur - 1'b1) state_d = ST_DONE;
            end
            ST_SCAN: begin
                if (chk_vld && (word_any || chk_k == '0)) state_d = ST_DONE;
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_sel   <= OP_EXP;
            rem_cnt   <= '0;
            pad_idx   <= '0;
            found_q   <= 1'b0;
            bit_len_q <= '0;
            res_len_q <= '0;
            scan_k    <= '0;
            scan_more <= 1'b0;
            chk_vld   <= 1'b0;
            chk_k     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ld_start) begin
                        cur_sel   <= ld_sel;
                        rem_cnt   <= ld_len;
                        pad_idx   <= ld_len;
                        found_q   <= 1'b0;
                        bit_len_q <= '0;
                    end else if (rd_start) begin
                        scan_k    <= WIDX_W'(DATA_WORDS - 1);
                        scan_more <= 1'b1;
                        chk_vld   <= 1'b0;
                    end
                end
                ST_LOAD: begin
                    if (byte_take) begin
                        rem_cnt <= rem_cnt - 1'b1;
                        if (!found_q && in_data != 8'h00) begin
                            found_q   <= 1'b1;
                            bit_len_q <= BITLEN_W'({wr_bidx, 3'b000}) + BITLEN_W'(msb_n);
                        end
                    end
                end
                ST_PAD: begin
                    pad_idx <= pad_idx + 1'b1;
                end
                ST_SCAN: begin
                    chk_vld <= scan_more;
                    chk_k   <= scan_k;
                    if (scan_more) begin
                        if (scan_k == '0) scan_more <= 1'b0;
                        else              scan_k    <= scan_k - 1'b1;
                    end
                    if (chk_vld) begin
                        if (word_any)
                            res_len_q <= LEN_W'({chk_k, 2'b00}) + LEN_W'(word_top);
                        else if (chk_k == '0)
                            res_len_q <= '0;
                    end
                end
                ST_DONE, ST_FAULT: begin
                    scan_more <= 1'b0;
                    chk_vld   <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = '0;
        done      = 1'b0;
        err       = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                in_ready  = 1'b1;
                mem_we    = in_valid;
                mem_wdata = {4{in_data}};
            end
            ST_PAD:   mem_we = 1'b1;
            ST_SCAN:  mem_re = scan_more;
            ST_DONE:  done   = 1'b1;
            ST_FAULT: begin
                done = 1'b1;
                err  = 1'b1;
            end
            default: ;
        endcase
        mem_addr = map_addr;
        mem_be   = 4'b0001 << wr_bidx[1:0];
        bit_len  = bit_len_q;
        res_len  = res_len_q;
    end

endmodule

// File: rtl/opmem_mapper_chk.sv
`timescale 1ns/1ps
module opmem_mapper_chk #(
    parameter int ADDR_W    = 11,
    parameter int TOP_WORDS = 1536
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_be,
    input logic              done,
    input logic              err,
    input logic              in_ready,
    input logic [1:0]        cur_sel
);
    AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (int'(mem_addr) < TOP_WORDS)); // R1

    AST_OWN_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((int'(mem_addr) % 12) / 4 == int'(cur_sel))); // R11

    AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(mem_be) == 1)); // R2

    AST_NO_RW_MIX: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !mem_re); // R3

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !mem_we && !in_ready)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
endmodule

bind opmem_mapper opmem_mapper_chk #(.ADDR_W(ADDR_W), .TOP_WORDS((DATA_BYTES / 4) * 3)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .mem_be   (mem_be),
    .done     (done),
    .err      (err),
    .in_ready (in_ready),
    .cur_sel  (cur_sel)
);

// File: tb/opmem_mapper_tb.sv
`timescale 1ns/1ps
module opmem_mapper_tb;
    localparam int DB = 2048;
    localparam int KB = 512;
    localparam int NW = 1536;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_start = 1'b0;
    logic [1:0]  ld_sel = '0;
    logic [11:0] ld_len = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        rd_start = 1'b0;
    logic        mem_we, mem_re;
    logic [10:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        done, err;
    logic [14:0] bit_len;
    logic [11:0] res_len;

    always #2.5 clk = ~clk;

    opmem_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_sel(ld_sel), .ld_len(ld_len),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .rd_start(rd_start),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done), .err(err),
        .bit_len(bit_len), .res_len(res_len)
    );

    // behavioural SRAM, pre-filled with a nonzero pattern during reset
    logic [31:0] mem [0:NW-1];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) mem[i] <= 32'hA5A5A5A5;
            mem_rdata <= '0;
        end else begin
            if (mem_we)
                for (int l = 0; l < 4; l++)
                    if (mem_be[l]) mem[mem_addr][8*l +: 8] <= mem_wdata[8*l +: 8];
            if (mem_re) mem_rdata <= mem[mem_addr];
        end
    end

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [7:0] img [0:NW*4-1];
    int q_a[$], q_b[$], q_d[$];
    logic [7:0] src[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int wmap(input int sel, input int k);
        return (k / 4) * 12 + sel * 4 + (k % 4);
    endfunction

    // every clock: each write must match the next expected write
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (q_a.size() == 0) begin
                chk(0, "R8", "unexpected write addr", mem_addr, 0);
            end else begin
                int a, b, d;
                a = q_a.pop_front(); b = q_b.pop_front(); d = q_d.pop_front();
                chk(mem_addr == a[10:0], "R1", "write address", mem_addr, a);
                chk(mem_be == b[3:0], "R2", "byte enable", mem_be, b);
                chk(mem_wdata == d, "R4", "write data", mem_wdata, d);
            end
        end
    end

    task automatic wait_done(input string req);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done && n < 6000);
        chk(done, req, "done seen", done, 1);
    endtask

    task automatic image_check(input string req);
        int bad = 0;
        for (int w = 0; w < NW; w++)
            if (mem[w] != {img[4*w+3], img[4*w+2], img[4*w+1], img[4*w]}) bad++;
        chk(bad == 0, req, "memory image mismatching dwords", bad, 0);
    endtask

    task automatic do_load(input int sel, input int len, input bit gaps, input string req);
        int cap, ebl;
        bit bad;
        cap = (sel == 2) ? DB : KB;
        bad = (sel == 3) || (len > cap);
        ebl = 0;
        if (!bad) begin
            for (int p = 0; p < len; p++) begin
                int r, a, l;
                r = len - 1 - p; a = wmap(sel, r / 4); l = r % 4;
                q_a.push_back(a); q_b.push_back(1 << l); q_d.push_back({4{src[p]}});
                img[4*a + l] = src[p];
                if (ebl == 0 && src[p] != 0) begin
                    int nb = 0;
                    for (int i = 0; i < 8; i++) if (src[p][i]) nb = i + 1;
                    ebl = 8 * r + nb;
                end
            end
            for (int r = len; r < cap; r++) begin
                int a = wmap(sel, r / 4);
                q_a.push_back(a); q_b.push_back(1 << (r % 4)); q_d.push_back(0);
                img[4*a + (r % 4)] = 8'h00;
            end
        end
        @(posedge clk); #1;
        ld_start = 1'b1; ld_sel = sel[1:0]; ld_len = len[11:0];
        @(posedge clk); #1;
        ld_start = 1'b0;
        if (bad) begin
            @(negedge clk);
            chk(done && err && !in_ready, "R8", "fault pulse in cycle after start", {done, err, in_ready}, 3'b110);
        end else begin
            for (int p = 0; p < len; p++) begin
                if (gaps && (p % 3 == 1)) begin
                    in_valid = 1'b0;
                    repeat (2) @(posedge clk);
                    #1;
                end
                in_valid = 1'b1; in_data = src[p];
                do @(negedge clk); while (!in_ready);
                @(posedge clk); #1;
                in_valid = 1'b0;
            end
            wait_done("R7");
            chk(err == 1'b0, "R8", "err on legal load", err, 0);
        end
        chk(bit_len == ebl, "R5", "bit length", bit_len, ebl);
        chk(q_a.size() == 0, "R4", "writes left over", q_a.size(), 0);
        @(negedge clk);
        chk(!done, "R7", "done single cycle", done, 0);
        image_check(req);
    endtask

    task automatic do_scan(input string req);
        int e = 0;
        for (int b = DB - 1; b >= 0; b--)
            if (e == 0 && img[4*wmap(2, b / 4) + (b % 4)] != 0) e = b + 1;
        @(posedge clk); #1; rd_start = 1'b1;
        @(posedge clk); #1; rd_start = 1'b0;
        wait_done("R7");
        chk(res_len == e, req, "result length", res_len, e);
    endtask

    initial begin
        for (int i = 0; i < NW * 4; i++) img[i] = 8'hA5;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk({done, err, in_ready, mem_we, mem_re} == 5'b0, "R10", "control outputs in reset",
            {done, err, in_ready, mem_we, mem_re}, 0);
        chk(bit_len == 0 && res_len == 0, "R10", "lengths in reset", bit_len, 0);
        #1 rst_n = 1'b1;

        // R5 leading zero bytes, with gaps in the stream (R3)
        src = '{8'h00, 8'h00, 8'h03, 8'hAB, 8'hCD};
        do_load(0, 5, 1, "R1");
        // modulus with top bit set
        src = '{8'h80, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
        do_load(1, 7, 0, "R11");
        // data, then readback
        src = '{8'h5A, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09};
        do_load(2, 10, 1, "R2");
        do_scan("R6");
        // all-zero exponent gives bit length 0
        src = '{8'h00, 8'h00, 8'h00, 8'h00};
        do_load(0, 4, 0, "R5");
        // rejected loads: oversize key, illegal select, oversize data
        src.delete();
        do_load(0, 513, 0, "R8");
        do_load(3, 4, 0, "R8");
        do_load(2, 2049, 0, "R8");
        // full-capacity modulus: no padding
        src.delete();
        for (int i = 0; i < KB; i++) src.push_back((i == 0) ? 8'h01 : 8'(i));
        do_load(1, KB, 0, "R9");
        // empty data: only padding, readback 0
        src.delete();
        do_load(2, 0, 0, "R9");
        do_scan("R6");
        // full-capacity data with top byte 1
        src.delete();
        for (int i = 0; i < DB; i++) src.push_back((i == 0) ? 8'h01 : 8'(i * 7));
        do_load(2, DB, 0, "R9");
        do_scan("R6");
        // inner zeros in data
        src = '{8'h00, 8'h00, 8'h12, 8'h00, 8'h34, 8'h56};
        do_load(2, 6, 1, "R4");
        do_scan("R6");

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule